// File: doc/BRIEF.md
# Integer ALU with Flag Control

This block is the one-cycle integer execute stage for a register-to-register and short-immediate instruction subset. Each cycle it may receive an 8-bit major opcode, the two 32-bit register operands (the destination/first source `ri_val` and the second source `rj_val`), and a 4-bit immediate field. In the same cycle it returns the value to be written back to the destination register, a write-enable, and an illegal-instruction indication. The four condition flags (negative, zero, overflow, carry) are held in a register inside the block, and the opcode decides which of them change at the next clock edge.

The subset covers addition (register, zero-extended immediate, minus-extended immediate), addition with carry, subtraction, subtraction with borrow, three compare forms, non-flag-setting addition and subtraction, and register-form AND, OR and XOR. A minus-extended immediate has its upper 28 bits forced to one, so it lies in -16..-1. Opcode bytes outside the subset are flagged as illegal and have no architectural effect.

Top module: `int_alu_flags`

## Requirements
- R1: Opcode 0xA6 yields `ri_val + rj_val`, 0xA4 yields `ri_val` plus the zero-extended immediate, 0xA5 yields `ri_val` plus the minus-extended immediate (`{28'hFFFFFFF, imm4}`); all three assert `res_we` and update all four flags.
- R2: Opcode 0xA7 yields `ri_val + rj_val + C` using the stored carry flag, asserts `res_we` and updates all four flags.
- R3: Opcodes 0xA2 (`ri_val + rj_val`), 0xA0 (zero-extended immediate add), 0xA1 (minus-extended immediate add) and 0xAE (`ri_val - rj_val`) assert `res_we` and leave all four flags unchanged.
- R4: Opcode 0xAC yields `ri_val - rj_val` and 0xAD yields `ri_val - rj_val - C`; both assert `res_we` and update all four flags.
- R5: Compare opcodes 0xAA (`ri_val - rj_val`), 0xA8 (minus zero-extended immediate) and 0xA9 (minus minus-extended immediate) update all four flags and keep `res_we` low.
- R6: Opcodes 0x82 (AND), 0x92 (OR) and 0x9A (XOR) yield the bitwise result, assert `res_we`, update N and Z, and keep V and C.
- R7: Any other opcode with `op_valid` high asserts `illegal`, keeps `res_we` low and leaves the flags unchanged.
- R8: Flag vector `nzvc` is {N, Z, V, C} in bits 3..0. N is result bit 31, Z is set when the 32-bit result is zero, V is signed two's-complement overflow, C is the carry-out for additions and a borrow for subtractions and compares (unsigned minuend smaller than subtrahend plus borrow-in).
- R9: `res`, `res_we` and `illegal` follow the inputs in the same cycle; `nzvc` changes at the clock edge that ends a valid instruction, never when `op_valid` is low, and reset clears it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Major opcode byte |
| ri_val | input | 32 | Destination register operand (first source) |
| rj_val | input | 32 | Second source register operand |
| imm4 | input | 4 | Short immediate field |
| res | output | 32 | Value for the destination register |
| res_we | output | 1 | Destination write enable |
| illegal | output | 1 | Undefined opcode presented |
| nzvc | output | 4 | Stored condition flags {N, Z, V, C} |

## Verification
The only hidden state is the flag register, so a wrong flag value is visible at `nzvc` one edge after the instruction that wrote it, and it also feeds forward into the very next add-with-carry or subtract-with-borrow, whose `res` is wrong in the same cycle it is presented. A flag that a non-flag-setting, logic or illegal instruction disturbs is caught by comparing `nzvc` against a bench model after every instruction, so corruption is reported within one cycle. Random opcodes and operands mixed with sign and carry boundary values exercise every overflow and borrow path.

// File: rtl/int_alu_flags.sv
module int_alu_flags #(
  parameter int W = 32,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [7:0]    opcode,
  input  logic [W-1:0]  ri_val,
  input  logic [W-1:0]  rj_val,
  input  logic [IW-1:0] imm4,
  output logic [W-1:0]  res,
  output logic          res_we,
  output logic          illegal,
  output logic [3:0]    nzvc
);

  localparam logic [7:0] OP_ADD   = 8'hA6, OP_ADDI  = 8'hA4, OP_ADDM  = 8'hA5;
  localparam logic [7:0] OP_ADDC  = 8'hA7;
  localparam logic [7:0] OP_ADDN  = 8'hA2, OP_ADDNI = 8'hA0, OP_ADDNM = 8'hA1;
  localparam logic [7:0] OP_SUB   = 8'hAC, OP_SUBC  = 8'hAD, OP_SUBN  = 8'hAE;
  localparam logic [7:0] OP_CMP   = 8'hAA, OP_CMPI  = 8'hA8, OP_CMPM  = 8'hA9;
  localparam logic [7:0] OP_AND   = 8'h82, OP_OR    = 8'h92, OP_XOR   = 8'h9A;

  typedef enum logic [2:0] {K_ADD, K_SUB, K_AND, K_OR, K_XOR} kind_t;
  typedef enum logic [1:0] {F_NONE, F_NZ, F_ALL} fmode_t;
  typedef enum logic [1:0] {B_REG, B_ZEXT, B_MEXT} bsel_t;

  kind_t      kind;
  fmode_t     fmode;
  bsel_t      bsel;
  logic       use_cin, wr, bad;
  logic [W-1:0] opb;
  logic [W:0]   sum, dif;
  logic         v_add, v_sub, n_f, z_f, v_f, c_f;

  always_comb begin
    kind = K_ADD; fmode = F_NONE; bsel = B_REG; use_cin = 1'b0; wr = 1'b0; bad = 1'b0;
    case (opcode)
      OP_ADD:   begin fmode = F_ALL; wr = 1'b1; end
      OP_ADDI:  begin fmode = F_ALL; wr = 1'b1; bsel = B_ZEXT; end
      OP_ADDM:  begin fmode = F_ALL; wr = 1'b1; bsel = B_MEXT; end
      OP_ADDC:  begin fmode = F_ALL; wr = 1'b1; use_cin = 1'b1; end
      OP_ADDN:  wr = 1'b1;
      OP_ADDNI: begin wr = 1'b1; bsel = B_ZEXT; end
      OP_ADDNM: begin wr = 1'b1; bsel = B_MEXT; end
      OP_SUB:   begin kind = K_SUB; fmode = F_ALL; wr = 1'b1; end
      OP_SUBC:  begin kind = K_SUB; fmode = F_ALL; wr = 1'b1; use_cin = 1'b1; end
      OP_SUBN:  begin kind = K_SUB; wr = 1'b1; end
      OP_CMP:   begin kind = K_SUB; fmode = F_ALL; end
      OP_CMPI:  begin kind = K_SUB; fmode = F_ALL; bsel = B_ZEXT; end
      OP_CMPM:  begin kind = K_SUB; fmode = F_ALL; bsel = B_MEXT; end
      OP_AND:   begin kind = K_AND; fmode = F_NZ; wr = 1'b1; end
      OP_OR:    begin kind = K_OR;  fmode = F_NZ; wr = 1'b1; end
      OP_XOR:   begin kind = K_XOR; fmode = F_NZ; wr = 1'b1; end
      default:  bad = 1'b1;
    endcase
  end

  always_comb
    case (bsel)
      B_ZEXT:  opb = {{(W-IW){1'b0}}, imm4};
      B_MEXT:  opb = {{(W-IW){1'b1}}, imm4};
      default: opb = rj_val;
    endcase

  wire cin = use_cin & nzvc[0];

  assign sum = {1'b0, ri_val} + {1'b0, opb} + {{W{1'b0}}, cin};
  assign dif = {1'b0, ri_val} - {1'b0, opb} - {{W{1'b0}}, cin};

  assign v_add = (ri_val[W-1] == opb[W-1]) && (sum[W-1] != ri_val[W-1]);
  assign v_sub = (ri_val[W-1] != opb[W-1]) && (dif[W-1] != ri_val[W-1]);

  always_comb
    case (kind)
      K_ADD:   res = sum[W-1:0];
      K_SUB:   res = dif[W-1:0];
      K_AND:   res = ri_val & rj_val;
      K_OR:    res = ri_val | rj_val;
      K_XOR:   res = ri_val ^ rj_val;
      default: res = '0;
    endcase

  assign n_f = res[W-1];
  assign z_f = (res == '0);
  assign v_f = (kind == K_SUB) ? v_sub : v_add;
  assign c_f = (kind == K_SUB) ? dif[W] : sum[W];

  assign res_we  = op_valid & wr & ~bad;
  assign illegal = op_valid & bad;

  always_ff @(posedge clk)
    if (!rst_n)
      nzvc <= 4'b0000;
    else if (op_valid && !bad)
      case (fmode)
        F_ALL:   nzvc <= {n_f, z_f, v_f, c_f};
        F_NZ:    nzvc <= {n_f, z_f, nzvc[1:0]};
        default: nzvc <= nzvc;
      endcase

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !op_valid |=> $stable(nzvc)); // R9
  AST_QUIET_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (opcode == OP_ADDN || opcode == OP_ADDNI || opcode == OP_ADDNM || opcode == OP_SUBN) |=> $stable(nzvc)); // R3
  AST_CMP_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (opcode == OP_CMP || opcode == OP_CMPI || opcode == OP_CMPM) |-> !res_we); // R5
  AST_LOGIC_KEEP_VC: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (opcode == OP_AND || opcode == OP_OR || opcode == OP_XOR) |=> nzvc[1:0] == $past(nzvc[1:0])); // R6
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !res_we); // R7
  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(nzvc)); // R7
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !bad && fmode != F_NONE |=> nzvc[2] == ($past(res) == '0)); // R8
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !bad && fmode != F_NONE |=> nzvc[3] == $past(res[W-1])); // R8

endmodule

// File: tb/int_alu_flags_test.sv
module int_alu_flags_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [31:0] ri_val = '0, rj_val = '0;
  logic [3:0]  imm4 = '0;
  logic [31:0] res;
  logic        res_we, illegal;
  logic [3:0]  nzvc;

  int checks = 0, errors = 0;
  logic [3:0] exp_f = 4'b0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu_flags uut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .ri_val(ri_val), .rj_val(rj_val), .imm4(imm4), .res(res), .res_we(res_we),
    .illegal(illegal), .nzvc(nzvc));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // returns {illegal, we, res[31:0], flags[3:0]}
  function automatic logic [37:0] model(input logic [7:0] op, input logic [31:0] a, input logic [31:0] b,
                                        input logic [3:0] im, input logic [3:0] f);
    longint ua, ub, sa, sb, r, sr;
    logic [31:0] o;
    bit sub, cinu, we, all, nz, ill, v, c;
    longint ci;
    ill = 0; we = 1; all = 1; nz = 0; sub = 0; cinu = 0; o = b;
    case (op)
      8'hA6: ;
      8'hA4: o = {28'h0, im};
      8'hA5: o = {28'hFFFFFFF, im};
      8'hA7: cinu = 1;
      8'hA2: all = 0;
      8'hA0: begin all = 0; o = {28'h0, im}; end
      8'hA1: begin all = 0; o = {28'hFFFFFFF, im}; end
      8'hAC: sub = 1;
      8'hAD: begin sub = 1; cinu = 1; end
      8'hAE: begin sub = 1; all = 0; end
      8'hAA: begin sub = 1; we = 0; end
      8'hA8: begin sub = 1; we = 0; o = {28'h0, im}; end
      8'hA9: begin sub = 1; we = 0; o = {28'hFFFFFFF, im}; end
      8'h82, 8'h92, 8'h9A: begin all = 0; nz = 1; end
      default: begin ill = 1; we = 0; all = 0; end
    endcase
    ua = longint'({32'h0, a}); ub = longint'({32'h0, o});
    sa = longint'($signed(a)); sb = longint'($signed(o));
    ci = (cinu && f[0]) ? 1 : 0;
    if (op == 8'h82) r = longint'({32'h0, a & b});
    else if (op == 8'h92) r = longint'({32'h0, a | b});
    else if (op == 8'h9A) r = longint'({32'h0, a ^ b});
    else if (sub) r = ua - ub - ci;
    else r = ua + ub + ci;
    sr = sub ? sa - sb - ci : sa + sb + ci;
    v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    c = sub ? (ua < ub + ci) : (r > 64'sd4294967295);
    if (ill) r = 0;
    if (all) f = {r[31], r[31:0] == 32'h0, v, c};
    else if (nz) f = {r[31], r[31:0] == 32'h0, f[1:0]};
    return {ill, we, r[31:0], f};
  endfunction

  function automatic string rtag(input logic [7:0] op);
    case (op)
      8'hA6, 8'hA4, 8'hA5: return "R1";
      8'hA7: return "R2";
      8'hA2, 8'hA0, 8'hA1, 8'hAE: return "R3";
      8'hAC, 8'hAD: return "R4";
      8'hAA, 8'hA8, 8'hA9: return "R5";
      8'h82, 8'h92, 8'h9A: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run(input logic v, input logic [7:0] op, input logic [31:0] a, input logic [31:0] b, input logic [3:0] im);
    logic [37:0] m;
    string t;
    @(negedge clk);
    op_valid = v; opcode = op; ri_val = a; rj_val = b; imm4 = im;
    m = model(op, a, b, im, exp_f);
    t = rtag(op);
    #1;
    if (v) begin
      chk(res_we == m[36], {t, " write enable"}, 32'(res_we), 32'(m[36]));
      chk(illegal == m[37], {t, " illegal"}, 32'(illegal), 32'(m[37]));
      if (m[36]) chk(res == m[35:4], {t, " result"}, res, m[35:4]);
      exp_f = m[3:0];
    end else begin
      chk(!res_we && !illegal, "R9 idle outputs", {30'h0, res_we, illegal}, 32'h0);
    end
    @(posedge clk); #1;
    chk(nzvc == exp_f, v ? {t, "/R8 flags"} : "R9 idle flags", 32'(nzvc), 32'(exp_f));
    op_valid = 1'b0;
  endtask

  localparam logic [7:0] OPS [16] = '{8'hA6, 8'hA4, 8'hA5, 8'hA7, 8'hA2, 8'hA0, 8'hA1, 8'hAC,
                                     8'hAD, 8'hAE, 8'hAA, 8'hA8, 8'hA9, 8'h82, 8'h92, 8'h9A};

  function automatic logic [31:0] pick();
    case ($urandom % 6)
      0: return 32'h0;
      1: return 32'h7FFFFFFF;
      2: return 32'h80000000;
      3: return 32'hFFFFFFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk(nzvc == 4'b0000, "R9 reset flags", 32'(nzvc), 32'h0);
    rst_n = 1'b1;
    // directed corners
    run(1, 8'hA6, 32'h7FFFFFFF, 32'h1, 0);          // R1 signed overflow
    run(1, 8'hA4, 32'hFFFFFFFF, 0, 4'h1);           // R1 carry, zero
    run(1, 8'hA5, 32'h0, 0, 4'hF);                  // R1 minus ext -> -1
    run(1, 8'hA5, 32'h10, 0, 4'h0);                 // R1 minus ext -16 -> 0 with carry
    run(1, 8'hA7, 32'h1, 32'h1, 0);                 // R2 carry-in set from previous
    run(1, 8'hAC, 32'h0, 32'h1, 0);                 // R4 borrow
    run(1, 8'hAD, 32'h5, 32'h2, 0);                 // R4 borrow-in used -> 2
    run(1, 8'hAC, 32'h80000000, 32'h1, 0);          // R4 overflow
    run(1, 8'hA2, 32'h0, 32'h0, 0);                 // R3 flags unchanged despite zero result
    run(1, 8'hA1, 32'h5, 0, 4'h0);                  // R3
    run(1, 8'hAE, 32'h0, 32'h1, 0);                 // R3
    run(1, 8'hAA, 32'h3, 32'h3, 0);                 // R5 equal -> Z
    run(1, 8'hA9, 32'h0, 0, 4'hF);                  // R5 0 - (-1)
    run(1, 8'hAC, 32'h0, 32'h80000000, 0);          // sets V and C
    run(1, 8'h82, 32'hF0F0F0F0, 32'h0F0F0F0F, 0);   // R6 zero, V/C kept
    run(1, 8'h92, 32'h80000000, 32'h1, 0);          // R6 negative
    run(1, 8'h9A, 32'hFFFF0000, 32'hFF00FF00, 0);   // R6
    run(1, 8'h00, 32'h0, 32'h0, 0);                 // R7
    run(1, 8'hFF, 32'h1, 32'h1, 0);                 // R7
    run(0, 8'hAC, 32'h0, 32'h1, 0);                 // R9 idle, no flag update
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] op;
      op = ($urandom % 10 == 0) ? 8'($urandom) : OPS[$urandom % 16];
      run(($urandom % 8) != 0, op, pick(), pick(), 4'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule